// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a synchronous SRAM whose bus never needs an idle cycle when it turns around between reads and writes. Address and control are captured on one rising clock edge. The data phase of that access takes place in the next clock cycle, in either direction. Read data is not registered again before the outputs, so it appears flow-through during the cycle after the address. Write data present on the data inputs is captured into the array at the enabled edge that closes the data cycle.

A single load/advance input either starts a new access, taking an external address, or steps an internal two-bit burst counter. One address can therefore serve four consecutive words, in linear or interleaved order. The block also has a clock enable, three chip enables of mixed polarity, per-lane write selects and an asynchronous output enable. The bidirectional data bus is split into separate data-in, data-out and drive-enable signals. The array depth is set by a parameter.

Top module: `zbtSram`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), no access is pending and `dOutEn` is low until a new read is loaded.
- R2: A rising edge with `clkEnN` low, `loadN` low, all chip enables asserted and `readSel` high loads a read. During the following cycle `dOutEn` is high (when `outEnN` is low) and `dOut` shows the stored word at that address.
- R3: A load with `readSel` low starts a write. `dOutEn` is low in its data cycle, and the `dIn` value present at the next enabled rising edge is stored at the access address.
- R4: Lane i is bits [9i+8:9i] of the 36-bit word. A write updates lane i only if `laneWrN[i]` was low at the edge that loaded or advanced that data cycle. All other lanes keep their old contents.
- R5: Reads and writes may follow each other on consecutive edges in any mix with no idle cycle. A read loaded right after a write to the same address returns the newly written word.
- R6: The chip enables are active low (`chipEn1N`), active high (`chipEn2`) and active low (`chipEn3N`). A load edge with any of them deasserted starts no operation: `dOutEn` is low in the next cycle and the array is not changed.
- R7: An access that is already in its data cycle still completes when the next edge deselects the block. A pending write stores its `dIn` at that edge.
- R8: While `clkEnN` is high, rising edges are ignored. Every register holds, a pending read keeps driving the same word, and a pending write captures its data at the next enabled edge.
- R9: With `loadN` high at an enabled edge, an active access advances its burst count. With `burstLinear` high, the two low address bits run as the loaded value plus the count, modulo 4.
- R10: With `burstLinear` low, the two low address bits are the loaded low bits XOR the count (0, 1, 2, 3). The upper address bits never change during a burst.
- R11: `outEnN` high forces `dOutEn` low at once, without waiting for a clock edge, and changes no internal state.
- R12: Advancing while deselected keeps the block deselected, with `dOutEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clkEnN | input | 1 | Clock enable, active low |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| loadN | input | 1 | Low: load new address; high: advance burst |
| readSel | input | 1 | Direction of a new access: 1 read, 0 write |
| laneWrN | input | 4 | Per-lane write selects, active low |
| burstLinear | input | 1 | Burst order: 1 linear, 0 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dIn | input | 4*LANE_W | Write data |
| dOut | output | 4*LANE_W | Flow-through read data |
| dOutEn | output | 1 | Data bus drive enable |

## Verification
The bench targets the turnaround cases: a write loaded directly after a read, and a read of the address that the previous edge has just written. A design that delays write data by one cycle, or that reads before the write lands, returns stale words in these cases. Burst bases with low bits 01 separate linear order from interleaved order, so a design that used the wrong order or carried into the upper bits would read the wrong address. Other checks cover a write held over suspended edges, which must take its data only at the enabled edge, a write still completing across a deselect, and a deselected write load that leaves the array untouched. A random mix of these patterns runs against a reference memory kept in the bench.

// File: rtl/zbtSramPkg.sv
package zbtSramPkg;
  localparam int LANES   = 4;
  localparam int BURST_W = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic               loadNow;   // capture external address this edge
    logic               writeNow;  // commit write data this edge
    logic               active;    // a data cycle is in progress
    logic               isWrite;   // direction of the data cycle
    logic [BURST_W-1:0] burstIdx;  // count within the 4-word burst
    logic [LANES-1:0]   laneWe;    // lane write enables, active high
  } zbtStrobeT;
endpackage

// File: rtl/zbtSramCtrl.sv
module zbtSramCtrl
  import zbtSramPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clkEnN,
  input  logic             chipEn1N,
  input  logic             chipEn2,
  input  logic             chipEn3N,
  input  logic             loadN,
  input  logic             readSel,
  input  logic [LANES-1:0] laneWrN,
  output zbtStrobeT        strobe
);
  logic               enabled;
  logic               chipSel;
  logic               activeQ;
  logic               isWriteQ;
  logic [BURST_W-1:0] burstQ;
  logic [LANES-1:0]   laneWeQ;

  always_comb begin
    enabled = !clkEnN && !rst;
    chipSel = !chipEn1N && chipEn2 && !chipEn3N;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ  <= 1'b0;
      isWriteQ <= 1'b0;
      burstQ   <= '0;
      laneWeQ  <= '0;
    end else if (!clkEnN) begin
      laneWeQ <= ~laneWrN;
      if (!loadN) begin
        activeQ  <= chipSel;
        isWriteQ <= !readSel;
        burstQ   <= '0;
      end else if (activeQ) begin
        burstQ <= burstQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadNow  = enabled && !loadN && chipSel;
    strobe.writeNow = enabled && activeQ && isWriteQ;
    strobe.active   = activeQ;
    strobe.isWrite  = isWriteQ;
    strobe.burstIdx = burstQ;
    strobe.laneWe   = laneWeQ;
  end
endmodule

// File: rtl/zbtSramDatapath.sv
module zbtSramDatapath
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  zbtStrobeT               strobe,
  input  logic                    burstLinear,
  input  logic                    outEnN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]       baseAddr;
  logic [BURST_W-1:0]      lowBits;
  logic [ADDR_W-1:0]       effAddr;
  logic [LANES*LANE_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (strobe.loadNow) baseAddr <= addr;
  end

  always_comb begin
    if (burstLinear) lowBits = baseAddr[BURST_W-1:0] + strobe.burstIdx;
    else             lowBits = baseAddr[BURST_W-1:0] ^ strobe.burstIdx;
    effAddr = {baseAddr[ADDR_W-1:BURST_W], lowBits};
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.writeNow && strobe.laneWe[g])
        laneMem[effAddr] <= dIn[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[effAddr];
  end

  assign dOut   = rdWord;
  assign dOutEn = strobe.active && !strobe.isWrite && !outEnN;
endmodule

// File: rtl/zbtSram.sv
module zbtSram
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clkEnN,
  input  logic                    chipEn1N,
  input  logic                    chipEn2,
  input  logic                    chipEn3N,
  input  logic                    loadN,
  input  logic                    readSel,
  input  logic [3:0]              laneWrN,
  input  logic                    burstLinear,
  input  logic                    outEnN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [4*LANE_W-1:0]     dIn,
  output logic [4*LANE_W-1:0]     dOut,
  output logic                    dOutEn
);
  zbtStrobeT strobe;

  zbtSramCtrl uCtrl (
    .clk(clk), .rst(rst), .clkEnN(clkEnN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .loadN(loadN), .readSel(readSel), .laneWrN(laneWrN),
    .strobe(strobe)
  );

  zbtSramDatapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uData (
    .clk(clk), .strobe(strobe), .burstLinear(burstLinear),
    .outEnN(outEnN), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: rtl/zbtSramChecker.sv
module zbtSramChecker (
  input logic clk,
  input logic rst,
  input logic clkEnN,
  input logic chipEn1N,
  input logic chipEn2,
  input logic chipEn3N,
  input logic loadN,
  input logic readSel,
  input logic outEnN,
  input logic dOutEn
);
  logic selAll;
  assign selAll = !chipEn1N && chipEn2 && !chipEn3N;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> !dOutEn);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !loadN && selAll && readSel) |=> (outEnN || dOutEn));

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !loadN && selAll && !readSel) |=> !dOutEn);

  assert_deselect_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !loadN && !selAll) |=> !dOutEn);

  assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> ($stable(dOutEn) || (outEnN != $past(outEnN))));

  assert_oe_forces_off_R11: assert property (@(posedge clk) disable iff (rst)
    outEnN |-> !dOutEn);
endmodule

bind zbtSram zbtSramChecker uChk (
  .clk(clk), .rst(rst), .clkEnN(clkEnN),
  .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
  .loadN(loadN), .readSel(readSel), .outEnN(outEnN), .dOutEn(dOutEn)
);

// File: tb/tb_zbtSram.sv
module tb_zbtSram;
  localparam int PERIOD = 10;
  localparam int A      = 6;
  localparam int LW     = 9;
  localparam int W      = 4 * LW;
  localparam int DEPTH  = 1 << A;

  logic         clk = 1'b0;
  logic         rst;
  logic         clkEnN, chipEn1N, chipEn2, chipEn3N, loadN, readSel;
  logic [3:0]   laneWrN;
  logic         burstLinear, outEnN;
  logic [A-1:0] addr;
  logic [W-1:0] dIn, dOut;
  logic         dOutEn;

  zbtSram #(.ADDR_W(A), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .clkEnN(clkEnN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .loadN(loadN), .readSel(readSel), .laneWrN(laneWrN),
    .burstLinear(burstLinear), .outEnN(outEnN), .addr(addr),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model
  logic [W-1:0] refMem [DEPTH];
  bit           mAct, mWr;
  logic [A-1:0] mBase;
  logic [1:0]   mCnt;
  logic [3:0]   mLanes;

  function automatic logic [A-1:0] effOf(logic [A-1:0] b, logic [1:0] c, bit lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
    return {b[A-1:2], lo};
  endfunction

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [3:0] en);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (en[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // sel: 0 all chip enables asserted, 1..3 that one deasserted
  task automatic step(string tag, bit ld, bit rd, int sel, bit cen,
                      logic [3:0] bw, logic [A-1:0] a, logic [W-1:0] d, bit oe);
    bit expEn;
    @(negedge clk);
    loadN = ld; readSel = rd; clkEnN = cen; laneWrN = bw;
    addr = a; dIn = d; outEnN = oe;
    chipEn1N = (sel == 1); chipEn2 = (sel != 2); chipEn3N = (sel == 3);
    @(posedge clk);
    if (!cen) begin
      if (mAct && mWr) begin
        logic [A-1:0] wa;
        wa = effOf(mBase, mCnt, burstLinear);
        refMem[wa] = merge(refMem[wa], d, mLanes);
      end
      if (!ld) begin
        mAct = (sel == 0); mWr = !rd; mBase = a; mCnt = 2'd0;
      end else if (mAct) begin
        mCnt = mCnt + 2'd1;
      end
      mLanes = ~bw;
    end
    #1;
    expEn = mAct && !mWr && !oe;
    check({tag, " dOutEn"}, W'(dOutEn), W'(expEn));
    if (expEn) check({tag, " dOut"}, dOut, refMem[effOf(mBase, mCnt, burstLinear)]);
  endtask

  function automatic logic [W-1:0] rndWord();
    return W'({$urandom, $urandom});
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    int seed;
    seed = $urandom(32'h1a2b);
    rst = 1'b1; clkEnN = 1'b0; loadN = 1'b1; readSel = 1'b1;
    chipEn1N = 1'b1; chipEn2 = 1'b0; chipEn3N = 1'b1;
    laneWrN = 4'hf; burstLinear = 1'b1; outEnN = 1'b0; addr = '0; dIn = '0;
    mAct = 0; mWr = 0; mBase = '0; mCnt = '0; mLanes = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R1 reset", W'(dOutEn), W'(0));

    // R3/R5: fill the array with back-to-back writes
    prev = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [W-1:0] nw;
      nw = rndWord();
      step("R3 fill", 0, 0, 0, 0, 4'h0, A'(i), prev, 0);
      prev = nw;
    end
    // R7: the last write completes on a deselect edge
    step("R7 deselect", 0, 1, 2, 0, 4'h0, '0, prev, 0);
    step("R7 readback", 0, 1, 0, 0, 4'h0, A'(DEPTH-1), '0, 0);
    step("R2 read", 0, 1, 0, 0, 4'h0, A'(5), '0, 0);

    // R5: turnaround with the same address
    step("R5 wr", 0, 0, 0, 0, 4'h0, A'(9), '0, 0);
    step("R5 rd", 0, 1, 0, 0, 4'h0, A'(9), W'(36'h123456789), 0);
    step("R5 wr2", 0, 0, 0, 0, 4'h0, A'(10), '0, 0);
    step("R5 rd2", 0, 1, 0, 0, 4'h0, A'(10), W'(36'h987654321), 0);

    // R4: partial lane write, lanes 0 and 2 only
    step("R4 wr", 0, 0, 0, 0, 4'b1010, A'(12), '0, 0);
    step("R4 rd", 0, 1, 0, 0, 4'h0, A'(12), W'(36'hfffffffff), 0);

    // R6: deselected write load leaves the array alone
    for (int s = 1; s <= 3; s++) begin
      step("R6 ld", 0, 0, s, 0, 4'h0, A'(20), '0, 0);
      step("R6 junk", 0, 1, s, 0, 4'h0, A'(20), W'(36'habcabcabc), 0);
      step("R6 rd", 0, 1, 0, 0, 4'h0, A'(20), '0, 0);
    end

    // R8: suspended edges hold a read and a pending write
    step("R8 rd", 0, 1, 0, 0, 4'h0, A'(30), '0, 0);
    step("R8 hold", 0, 0, 0, 1, 4'h0, A'(31), '0, 0);
    step("R8 hold2", 1, 0, 0, 1, 4'h0, A'(31), '0, 0);
    step("R8 wr", 0, 0, 0, 0, 4'h0, A'(31), '0, 0);
    step("R8 susp", 0, 1, 1, 1, 4'h0, A'(0), W'(36'h111111111), 0);
    step("R8 data", 0, 1, 0, 0, 4'h0, A'(31), W'(36'h222222222), 0);

    // R9: linear burst from base 5 -> 5,6,7,4
    burstLinear = 1'b1;
    step("R9 ld", 0, 1, 0, 0, 4'h0, A'(5), '0, 0);
    for (int k = 0; k < 4; k++) step("R9 adv", 1, 1, 0, 0, 4'h0, '0, '0, 0);
    // R10: interleaved burst from base 5 -> 5,4,7,6
    burstLinear = 1'b0;
    step("R10 ld", 0, 1, 0, 0, 4'h0, A'(5), '0, 0);
    for (int k = 0; k < 3; k++) step("R10 adv", 1, 1, 0, 0, 4'h0, '0, '0, 0);
    step("R10 wburst", 0, 0, 0, 0, 4'h0, A'(41), '0, 0);
    for (int k = 0; k < 3; k++) step("R10 wadv", 1, 1, 0, 0, 4'h0, '0, rndWord(), 0);
    step("R10 wend", 0, 1, 0, 0, 4'h0, A'(40), rndWord(), 0);
    for (int k = 0; k < 3; k++) step("R10 radv", 1, 1, 0, 0, 4'h0, '0, '0, 0);

    // R11: output enable forces drive off
    step("R11 rd", 0, 1, 0, 0, 4'h0, A'(7), '0, 1);
    step("R11 rd2", 0, 1, 0, 0, 4'h0, A'(8), '0, 0);
    // R12: advancing while deselected
    step("R12 desel", 0, 1, 3, 0, 4'h0, A'(8), '0, 0);
    step("R12 adv", 1, 1, 0, 0, 4'h0, '0, '0, 0);
    step("R12 adv2", 1, 0, 0, 0, 4'h0, '0, '0, 0);

    // random mix (R5)
    for (int n = 0; n < 3000; n++) begin
      int sel;
      if (n % 500 == 0) burstLinear = $urandom % 2;
      sel = ($urandom % 8 == 0) ? int'(1 + $urandom % 3) : 0;
      step("R5 random", ($urandom % 10) >= 7, $urandom % 2, sel,
           ($urandom % 10) == 0, ($urandom % 3 == 0) ? 4'($urandom) : 4'h0,
           A'($urandom), rndWord(), ($urandom % 12) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule